// File: doc/BRIEF.md
# Lane-Partitioned Saturating Adder/Subtractor

This block adds or subtracts two 64-bit operands as a vector of signed elements. The carry chain is cut at element boundaries. The same datapath therefore serves eight 8-bit elements, four 16-bit elements, two 32-bit elements, or one 64-bit element. Each element is treated as an independent two's-complement number with its own overflow detection.

With clamping enabled, an element whose true result falls outside its signed range takes the nearest limit: the largest positive value or the most negative value. With clamping disabled, every element wraps modulo two to the power of its width. A per-byte overflow flag vector reports which elements went out of range, whatever the clamping setting.

The arithmetic is purely combinational. A parameter places a register on the outputs, which is the default. It is meant for media-style loops that process packed samples, such as audio clipping and pixel arithmetic.

Top module: `simd_sat_adder`

## Requirements
- R1: `laneSel` picks the element width: 2'b00 gives 8-bit elements, 2'b01 gives 16-bit, 2'b10 gives 32-bit and 2'b11 gives one 64-bit element. No carry or borrow ever crosses from one element into the next.
- R2: With `satEn` low and `subEn` low, each element of `result` equals the low bits of the sum of the matching elements of `opA` and `opB`, that is, the sum modulo 2^width.
- R3: With `subEn` high, each element is computed as `opA` plus the bitwise inverse of `opB` plus one within that element. This is two's-complement subtraction, wrapping when `satEn` is low.
- R4: In addition, an element overflows exactly when both operands have the same sign and the sign of the wrapped result differs from it. Operands of opposite sign never overflow.
- R5: In subtraction, an element overflows exactly when a non-negative `opA` element minus a negative `opB` element gives a negative wrapped result, or a negative `opA` element minus a non-negative `opB` element gives a non-negative wrapped result.
- R6: With `satEn` high, an element with positive overflow outputs its largest positive value. The element's top byte is 0x7F and every lower byte is 0xFF.
- R7: With `satEn` high, an element with negative overflow outputs its most negative value. The element's top byte is 0x80 and every lower byte is 0x00.
- R8: `laneOvf[k]` belongs to byte k, which is `result[8k+7:8k]`. All bytes of one element carry the same flag value.
- R9: Overflow flags are reported identically whether `satEn` is high or low.
- R10: With the default output register, `result` and `laneOvf` update at the first rising clock edge after the inputs change. While `rstN` is low, both read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low synchronous reset of the output register |
| opA | input | 64 | First operand, packed signed elements |
| opB | input | 64 | Second operand, packed signed elements |
| laneSel | input | 2 | Element width code |
| subEn | input | 1 | 1 = opA minus opB, 0 = opA plus opB |
| satEn | input | 1 | 1 = clamp overflowing elements, 0 = wrap |
| result | output | 64 | Packed element results |
| laneOvf | output | 8 | Per-byte overflow flags |

## Verification
The bench sweeps every element width, both operations and both clamping settings. It crosses the eight boundary values of each width: zero, one, the two largest positives, the two most negative values, minus one and minus two. It also adds random vectors.

A design that leaks a carry across an element boundary would corrupt the neighbouring element by one. A design that forgets to inject the subtract carry per element would be off by one in every element above the lowest. A design that clamps below the top byte with the wrong constant would output 0x7F in the middle of a wider element. A design that judges overflow from the wrong sign bits would miss the minimum-minus-one and maximum-plus-one cases, or would flag opposite-sign sums.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int SIMD_BYTES = 8;
  localparam int BYTE_BITS  = 8;
  localparam int DATA_BITS  = SIMD_BYTES * BYTE_BITS;
  localparam int IDX_BITS   = $clog2(SIMD_BYTES);

  typedef enum logic [1:0] {
    LANE_B8  = 2'b00,
    LANE_B16 = 2'b01,
    LANE_B32 = 2'b10,
    LANE_B64 = 2'b11
  } laneSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                subOp;
    logic                satOn;
    logic [IDX_BITS-1:0] laneMask; // bytes per element minus one
  } laneCtrl_t;
endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
(
  input  logic [1:0] laneSel,
  input  logic       subEn,
  input  logic       satEn,
  output laneCtrl_t  strobes
);
  laneSel_e selCode;
  logic [IDX_BITS:0] laneBytes;

  always_comb begin
    selCode   = laneSel_e'(laneSel);
    laneBytes = (IDX_BITS+1)'(1) << selCode;
    if (laneBytes > (IDX_BITS+1)'(SIMD_BYTES))
      laneBytes = (IDX_BITS+1)'(SIMD_BYTES);
    strobes.subOp    = subEn;
    strobes.satOn    = satEn;
    strobes.laneMask = IDX_BITS'(laneBytes - (IDX_BITS+1)'(1));
  end
endmodule

// File: rtl/simd_datapath.sv
module simd_datapath
  import simd_pkg::*;
(
  input  logic [DATA_BITS-1:0]  opA,
  input  logic [DATA_BITS-1:0]  opB,
  input  laneCtrl_t             strobes,
  output logic [DATA_BITS-1:0]  sumOut,
  output logic [SIMD_BYTES-1:0] ovfOut
);
  localparam logic [BYTE_BITS-1:0] TOP_POS = {1'b0, {(BYTE_BITS-1){1'b1}}};
  localparam logic [BYTE_BITS-1:0] TOP_NEG = {1'b1, {(BYTE_BITS-1){1'b0}}};

  logic [SIMD_BYTES-1:0] carryIn, carryOut, isFirst, isLast, ovfPos, ovfNeg;
  logic [DATA_BITS-1:0]  rawSum, opBMod;

  // byte slices of the partitioned carry chain
  for (genvar b = 0; b < SIMD_BYTES; b++) begin : gByte
    localparam logic [IDX_BITS-1:0] IDX = IDX_BITS'(b);
    logic aMsb, bMsb, sMsb;

    assign isFirst[b] = (IDX & strobes.laneMask) == '0;
    assign isLast[b]  = (IDX & strobes.laneMask) == strobes.laneMask;
    assign opBMod[b*BYTE_BITS +: BYTE_BITS] =
      opB[b*BYTE_BITS +: BYTE_BITS] ^ {BYTE_BITS{strobes.subOp}};

    if (b == 0) begin : gLow
      assign carryIn[b] = strobes.subOp;
    end else begin : gUp
      assign carryIn[b] = isFirst[b] ? strobes.subOp : carryOut[b-1];
    end

    assign {carryOut[b], rawSum[b*BYTE_BITS +: BYTE_BITS]} =
      {1'b0, opA[b*BYTE_BITS +: BYTE_BITS]} +
      {1'b0, opBMod[b*BYTE_BITS +: BYTE_BITS]} +
      (BYTE_BITS+1)'(carryIn[b]);

    assign aMsb = opA[b*BYTE_BITS + BYTE_BITS-1];
    assign bMsb = opBMod[b*BYTE_BITS + BYTE_BITS-1];
    assign sMsb = rawSum[b*BYTE_BITS + BYTE_BITS-1];
    assign ovfPos[b] = isLast[b] & ~aMsb & ~bMsb &  sMsb;
    assign ovfNeg[b] = isLast[b] &  aMsb &  bMsb & ~sMsb;
  end

  // spread the element flag over its bytes and clamp
  for (genvar b = 0; b < SIMD_BYTES; b++) begin : gSat
    localparam logic [IDX_BITS-1:0] IDX = IDX_BITS'(b);
    logic [IDX_BITS-1:0] endIdx;
    logic posHit, negHit;

    assign endIdx = IDX | strobes.laneMask;
    assign posHit = ovfPos[endIdx];
    assign negHit = ovfNeg[endIdx];
    assign ovfOut[b] = posHit | negHit;

    always_comb begin
      if (strobes.satOn && posHit)
        sumOut[b*BYTE_BITS +: BYTE_BITS] = isLast[b] ? TOP_POS : {BYTE_BITS{1'b1}};
      else if (strobes.satOn && negHit)
        sumOut[b*BYTE_BITS +: BYTE_BITS] = isLast[b] ? TOP_NEG : {BYTE_BITS{1'b0}};
      else
        sumOut[b*BYTE_BITS +: BYTE_BITS] = rawSum[b*BYTE_BITS +: BYTE_BITS];
    end
  end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
  import simd_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [DATA_BITS-1:0]  opA,
  input  logic [DATA_BITS-1:0]  opB,
  input  logic [1:0]            laneSel,
  input  logic                  subEn,
  input  logic                  satEn,
  output logic [DATA_BITS-1:0]  result,
  output logic [SIMD_BYTES-1:0] laneOvf
);
  localparam int TOP = DATA_BITS - 1;

  laneCtrl_t             strobes;
  logic [DATA_BITS-1:0]  sumComb;
  logic [SIMD_BYTES-1:0] ovfComb;

  simd_ctrl uCtrl (
    .laneSel (laneSel),
    .subEn   (subEn),
    .satEn   (satEn),
    .strobes (strobes)
  );

  simd_datapath uDp (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .sumOut  (sumComb),
    .ovfOut  (ovfComb)
  );

  if (REG_OUT) begin : gReg
    logic checkValid;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        result     <= '0;
        laneOvf    <= '0;
        checkValid <= 1'b0;
      end else begin
        result     <= sumComb;
        laneOvf    <= ovfComb;
        checkValid <= 1'b1;
      end
    end

    AST_WRAP_FULL: assert property (@(posedge clk) disable iff (!rstN)
      checkValid && $past(!satEn && laneSel == LANE_B64) |->
        result == $past(subEn ? opA - opB : opA + opB)); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      checkValid && $past(!subEn && (opA[TOP] != opB[TOP])) |->
        !laneOvf[SIMD_BYTES-1]); // R4
    AST_SUB_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      checkValid && $past(subEn && (opA[TOP] == opB[TOP])) |->
        !laneOvf[SIMD_BYTES-1]); // R5
    AST_CLAMP_POS: assert property (@(posedge clk) disable iff (!rstN)
      checkValid && $past(satEn && !opA[TOP]) && laneOvf[SIMD_BYTES-1] |->
        result[TOP -: BYTE_BITS] == 8'h7F); // R6
    AST_CLAMP_NEG: assert property (@(posedge clk) disable iff (!rstN)
      checkValid && $past(satEn && opA[TOP]) && laneOvf[SIMD_BYTES-1] |->
        result[TOP -: BYTE_BITS] == 8'h80); // R7

    for (genvar b = 1; b < SIMD_BYTES; b += 2) begin : gFlagChk
      AST_FLAG_REPLICATED: assert property (@(posedge clk) disable iff (!rstN)
        checkValid && $past(laneSel != LANE_B8) |->
          laneOvf[b] == laneOvf[b-1]); // R8
    end
  end else begin : gComb
    assign result  = sumComb;
    assign laneOvf = ovfComb;
  end
endmodule

// File: tb/tb_simd_sat_adder.sv
module tb_simd_sat_adder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] opA = '0, opB = '0;
  logic [1:0]  laneSel = '0;
  logic        subEn = 1'b0, satEn = 1'b0;
  logic [63:0] result;
  logic [7:0]  laneOvf;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk; // 250 MHz

  simd_sat_adder dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .laneSel(laneSel),
    .subEn(subEn), .satEn(satEn), .result(result), .laneOvf(laneOvf)
  );

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void refModel(input logic [63:0] a, input logic [63:0] b,
                                   input int mode, input bit sub, input bit sat,
                                   output logic [63:0] r, output logic [7:0] f);
    int w;
    logic [63:0] la, lb;
    logic signed [66:0] sa, sb, sr, mx, mn;
    bit ovf;
    w = 8 << mode;
    r = '0;
    f = '0;
    for (int off = 0; off < 64; off += w) begin
      la = '0;
      lb = '0;
      for (int k = 0; k < w; k++) begin
        la[k] = a[off+k];
        lb[k] = b[off+k];
      end
      sa = signed'({3'b0, la});
      sb = signed'({3'b0, lb});
      if (la[w-1]) sa = sa - (67'sd1 <<< w);
      if (lb[w-1]) sb = sb - (67'sd1 <<< w);
      sr = sub ? sa - sb : sa + sb;
      mx = (67'sd1 <<< (w-1)) - 67'sd1;
      mn = -(67'sd1 <<< (w-1));
      ovf = (sr > mx) || (sr < mn);
      if (sat && ovf) sr = (sr > mx) ? mx : mn;
      for (int k = 0; k < w; k++) r[off+k] = sr[k];
      if (ovf) for (int k = 0; k < w/8; k++) f[off/8+k] = 1'b1;
    end
  endfunction

  function automatic logic [63:0] cornerVal(input int sel, input int w);
    logic [63:0] msk, minV;
    msk  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    minV = 64'd1 << (w-1);
    case (sel % 8)
      0: return 64'd0;
      1: return 64'd1;
      2: return (minV - 64'd2) & msk;
      3: return (minV - 64'd1) & msk;
      4: return minV & msk;
      5: return (minV + 64'd1) & msk;
      6: return msk;
      default: return (msk - 64'd1) & msk;
    endcase
  endfunction

  task automatic runVec(input logic [63:0] a, input logic [63:0] b,
                        input int mode, input bit sub, input bit sat);
    logic [63:0] er;
    logic [7:0]  ef;
    string tagR, tagF;
    @(negedge clk);
    opA = a; opB = b; laneSel = 2'(mode); subEn = sub; satEn = sat;
    @(negedge clk);
    refModel(a, b, mode, sub, sat, er, ef);
    if (sat && ef != 0) tagR = "R6 R7 clamp";
    else if (sub)       tagR = "R3 subtract";
    else                tagR = "R2 wrap add";
    tagF = sub ? "R5 R8 flags" : "R4 R8 flags";
    check64(tagR, result, er);
    check64(tagF, {56'd0, laneOvf}, {56'd0, ef});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [63:0] a, b;
    int w;
    repeat (3) @(negedge clk);
    // R10 reset state
    opA = '1; opB = '1; satEn = 1'b1;
    @(negedge clk);
    check64("R10 reset result", result, 64'd0);
    check64("R10 reset flags", {56'd0, laneOvf}, 64'd0);
    rstN = 1'b1;

    // R1 carry isolation at element boundaries
    runVec(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 0, 1'b0, 1'b0);
    check64("R1 8-bit cut", result, 64'h0);
    runVec(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 1, 1'b0, 1'b0);
    check64("R1 16-bit join", result, 64'h0100_0100_0100_0100);
    runVec(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 3, 1'b0, 1'b0);
    check64("R1 64-bit join", result, 64'h0000_0001_0000_0000);

    // R4 R9 positive overflow reported with clamping off, R6 with it on
    runVec({8{8'h7F}}, {8{8'h01}}, 0, 1'b0, 1'b0);
    check64("R9 wrap result", result, {8{8'h80}});
    check64("R9 flags without clamp", {56'd0, laneOvf}, 64'hFF);
    runVec({8{8'h7F}}, {8{8'h01}}, 0, 1'b0, 1'b1);
    check64("R6 clamp 8-bit", result, {8{8'h7F}});

    // R5 R7 subtract underflow in 32-bit elements
    runVec(64'h8000_0000_0000_0000, 64'h0000_0001_0000_0001, 2, 1'b1, 1'b1);
    check64("R7 clamp 32-bit", result, 64'h8000_0000_FFFF_FFFF);
    check64("R5 R8 flags 32-bit", {56'd0, laneOvf}, 64'hF0);

    // R10 output holds until the next rising edge
    @(negedge clk);
    opA = 64'h1; opB = 64'h1; laneSel = 2'd3; subEn = 1'b0; satEn = 1'b0;
    #1;
    check64("R10 holds before edge", result, 64'h8000_0000_FFFF_FFFF);
    @(negedge clk);
    check64("R10 updates after edge", result, 64'h2);

    // corner-value sweep
    for (int mode = 0; mode < 4; mode++) begin
      w = 8 << mode;
      for (int op = 0; op < 4; op++) begin
        for (int i = 0; i < 8; i++) begin
          for (int j = 0; j < 8; j++) begin
            a = '0;
            b = '0;
            for (int l = 0; l < 64 / w; l++) begin
              a = a | (cornerVal(i + l, w) << (l * w));
              b = b | (cornerVal(j + 3 * l, w) << (l * w));
            end
            runVec(a, b, mode, op[0], op[1]);
          end
        end
      end
    end

    // random vectors
    for (int n = 0; n < 2000; n++) begin
      a = {$urandom(), $urandom()};
      b = {$urandom(), $urandom()};
      runVec(a, b, n % 4, n[2], n[3]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule